// File: doc/BRIEF.md
# Sequenced-Write Watchdog Timer

This block is a bus-programmed watchdog. Software programs a countdown period and a warning threshold through a small register port. A running timer must be serviced before the count runs out. If it is not, the block drives a reset request for a fixed number of clocks and stops itself. A level interrupt can warn software earlier, when the remaining count reaches a programmed threshold.

No single bus write can start, stop or service the timer. Each command needs a two-write handshake on its own 2-bit field of the control word: first the value 1 arms the field, and then the value 2 fires it. Any other value written to that field disarms it. Every control write also loads the reload value from its low bits. The period is counted in units of 256 clocks.

The control state machine has three states. `ST_OFF` means stopped. `ST_RUN` means counting down. `ST_BITE` means the reset pulse is being driven. It makes these transitions:
- `ST_OFF` to `ST_RUN` when the enable command fires.
- `ST_RUN` to `ST_OFF` when the enable command fires.
- `ST_RUN` to `ST_BITE` when the count is zero and no command fires.
- `ST_BITE` to `ST_OFF` after the last pulse cycle.

Each command field has its own handshake machine with two states. `HS_IDLE` moves to `HS_ARMED` on a write of 1. `HS_ARMED` returns to `HS_IDLE` on any other value, and a write of 2 in that state fires the command.

Top module: `seqwd_timer`

## Requirements
- R1: After reset the timer is stopped. `wdt_reset_o` and `wdt_irq_o` are low. The control word reads 0x00000010 (reload value 16), and the threshold word reads 0.
- R2: Every write to offset 0 stores bits 23:0 as the reload value. A read of offset 0 returns bit 31 = running, bit 30 = expiry flag, bits 23:0 = reload value, and zero in all other bits.
- R3: The enable command field is bits 25:24. A write of 1 to it arms the field. If the next write to offset 0 carries 2 in that field, the timer toggles between stopped and running at that write's clock edge. Idle cycles between the two writes are allowed.
- R4: A 2 written to a command field that is not armed has no effect. A write of 0 or 3 to an armed field disarms it, so a later 2 is ignored.
- R5: The service command field is bits 27:26 and uses the same 1-then-2 handshake. Firing it loads the count with the reload value carried by the firing write, multiplied by 256. This works whether the timer is running or stopped.
- R6: While running, the count drops by one each clock. If the service command fires at edge S, `wdt_reset_o` rises after edge S + reload×256 + 1.
- R7: On expiry, `wdt_reset_o` stays high for exactly 16 clocks. The timer then reads stopped and the expiry flag (bit 30) is set. The flag clears when the timer is next enabled.
- R8: While stopped, the count holds its value and `wdt_reset_o` never rises. After re-enabling, the countdown resumes from the held count.
- R9: The threshold register sits at offset 4, bits 23:0. While running with a nonzero threshold T, `wdt_irq_o` rises one clock after the count equals T×256. It then stays high until a service, a toggle or an expiry.
- R10: Commands that fire during the reset pulse are ignored. The pulse keeps its full length and the timer ends stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Byte offset of the register (0 = control, 4 = threshold) |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_reset_o | output | 1 | Reset request, high during the expiry pulse |
| wdt_irq_o | output | 1 | Level interrupt for the threshold warning |

## Verification
The assertions watch local rules on every cycle:
- a handshake field is disarmed by any value other than 1, and firing consumes the arm;
- the count holds when neither loading nor running, steps down by exactly one while running, and takes the loaded value;
- the reset pulse starts only from `ST_RUN`, is not cut short, and ends in `ST_OFF` with the flag set;
- the interrupt rises only while running.

Only the bench's scenarios can show the end-to-end behaviour. This covers the exact number of clocks from a service to the pulse, the pulse width, resuming from a held count, the interrupt delay for a given threshold, and that stray or interrupted command sequences leave the read-back status unchanged.

// File: rtl/seqwd_pkg.sv
`timescale 1ns/1ps
package seqwd_pkg;
    localparam int FLD_W    = 2;
    localparam int EN_LSB   = 24;
    localparam int SVC_LSB  = 26;
    localparam int RUN_BIT  = 31;
    localparam int FLAG_BIT = 30;

    localparam logic [FLD_W-1:0] CMD_ARM  = 2'd1;
    localparam logic [FLD_W-1:0] CMD_FIRE = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_BITE = 2'd2
    } wd_state_e;

    typedef enum logic {
        HS_IDLE  = 1'b0,
        HS_ARMED = 1'b1
    } hs_state_e;
endpackage

// File: rtl/seqwd_handshake.sv
`timescale 1ns/1ps
module seqwd_handshake
    import seqwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [FLD_W-1:0] code_i,
    output logic             fire_o
);
    hs_state_e st_q;
    hs_state_e st_d;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            unique case (st_q)
                HS_IDLE:  st_d = (code_i == CMD_ARM) ? HS_ARMED : HS_IDLE;
                HS_ARMED: st_d = (code_i == CMD_ARM) ? HS_ARMED : HS_IDLE;
                default:  st_d = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    assign fire_o = wr_i && (st_q == HS_ARMED) && (code_i == CMD_FIRE);

    // R4: an armed field is dropped by any value other than the arm code
    assert_disarm_on_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_ARMED && wr_i && code_i != CMD_ARM) |=> (st_q == HS_IDLE));

    // R3: firing consumes the arm, so a second 2 needs a new 1
    assert_fire_consumes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (st_q == HS_IDLE));
endmodule

// File: rtl/seqwd_countdown.sv
`timescale 1ns/1ps
module seqwd_countdown #(
    parameter int                  RELOAD_W   = 24,
    parameter int                  PRESCALE_W = 8,
    parameter logic [RELOAD_W-1:0] RST_RELOAD = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [RELOAD_W-1:0] load_val_i,
    input  logic                dec_i,
    input  logic [RELOAD_W-1:0] thr_i,
    output logic                zero_o,
    output logic                thr_hit_o
);
    localparam int                CNT_W = RELOAD_W + PRESCALE_W;
    localparam logic [CNT_W-1:0]  ONE   = CNT_W'(1);
    localparam logic [PRESCALE_W-1:0] LOW_ZERO = '0;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= {RST_RELOAD, LOW_ZERO};
        else if (load_i)
            cnt_q <= {load_val_i, LOW_ZERO};
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign zero_o    = (cnt_q == '0);
    assign thr_hit_o = (thr_i != '0) && (cnt_q == {thr_i, LOW_ZERO});

    // R8: nothing moves the count while it is neither loaded nor running
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !dec_i) |=> $stable(cnt_q));

    // R5: a load places reload x 256 in the count
    assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == {$past(load_val_i), LOW_ZERO}));

    // R6: one step per running clock
    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/seqwd_ctrl.sv
`timescale 1ns/1ps
module seqwd_ctrl
    import seqwd_pkg::*;
#(
    parameter int BITE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    input  logic service_i,
    input  logic zero_i,
    input  logic thr_hit_i,
    output logic load_o,
    output logic dec_o,
    output logic running_o,
    output logic expired_o,
    output logic rst_o,
    output logic irq_o
);
    localparam int            BW        = $clog2(BITE_CYCLES + 1);
    localparam logic [BW-1:0] BITE_LAST = BW'(BITE_CYCLES - 1);
    localparam logic [BW-1:0] BITE_ONE  = BW'(1);

    wd_state_e     state_q;
    wd_state_e     state_d;
    logic [BW-1:0] bite_q;
    logic          rst_q;
    logic          expired_q;
    logic          irq_q;

    logic toggle_ok;
    logic service_ok;
    logic expire_ev;

    assign toggle_ok  = toggle_i  && (state_q != ST_BITE);
    assign service_ok = service_i && (state_q != ST_BITE);
    assign expire_ev  = (state_q == ST_RUN) && !toggle_i && !service_i && zero_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (toggle_ok) state_d = ST_RUN;
            ST_RUN: begin
                if (toggle_ok)      state_d = ST_OFF;
                else if (expire_ev) state_d = ST_BITE;
            end
            ST_BITE: if (bite_q == BITE_LAST) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            bite_q  <= '0;
        end else begin
            state_q <= state_d;
            bite_q  <= (state_q == ST_BITE) ? bite_q + BITE_ONE : '0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_q     <= 1'b0;
            expired_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            rst_q <= (state_d == ST_BITE);
            if (expire_ev)
                expired_q <= 1'b1;
            else if (toggle_ok && state_q == ST_OFF)
                expired_q <= 1'b0;
            if (toggle_ok || service_ok || expire_ev)
                irq_q <= 1'b0;
            else if (state_q == ST_RUN && thr_hit_i)
                irq_q <= 1'b1;
        end
    end

    assign load_o    = service_ok || expire_ev;
    assign dec_o     = (state_q == ST_RUN);
    assign running_o = (state_q == ST_RUN);
    assign expired_o = expired_q;
    assign rst_o     = rst_q;
    assign irq_o     = irq_q;

    // R6: a reset pulse only starts out of the running state
    assert_pulse_from_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_q) |-> ($past(state_q) == ST_RUN));

    // R7: the pulse is not cut short
    assert_pulse_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BITE && bite_q != BITE_LAST) |=> rst_q);

    // R7: the pulse ends stopped with the flag raised
    assert_pulse_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_q) |-> (state_q == ST_OFF && expired_q));

    // R8: no pulse appears while stopped
    assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && $past(state_q) == ST_OFF) |-> !rst_q);

    // R9: the warning rises only while running
    assert_irq_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(state_q) == ST_RUN));

    // R10: commands cannot leave the pulse early
    assert_bite_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BITE && bite_q != BITE_LAST) |=> (state_q == ST_BITE));
endmodule

// File: rtl/seqwd_timer.sv
`timescale 1ns/1ps
module seqwd_timer
    import seqwd_pkg::*;
#(
    parameter int                  ADDR_W      = 3,
    parameter int                  RELOAD_W    = 24,
    parameter int                  PRESCALE_W  = 8,
    parameter int                  BITE_CYCLES = 16,
    parameter logic [RELOAD_W-1:0] RST_RELOAD  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_reset_o,
    output logic              wdt_irq_o
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_THR  = ADDR_W'(4);
    localparam int                N_CMD    = 2;

    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] reload_next;
    logic [RELOAD_W-1:0] thr_q;
    logic                wr_ctrl;
    logic                wr_thr;
    logic [N_CMD-1:0]    cmd_fire;

    logic load;
    logic dec;
    logic zero;
    logic thr_hit;
    logic running;
    logic expired;

    assign wr_ctrl     = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_thr      = bus_wr && (bus_addr == OFS_THR);
    assign reload_next = wr_ctrl ? bus_wdata[RELOAD_W-1:0] : reload_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= RST_RELOAD;
            thr_q    <= '0;
        end else begin
            if (wr_ctrl) reload_q <= bus_wdata[RELOAD_W-1:0];
            if (wr_thr)  thr_q    <= bus_wdata[RELOAD_W-1:0];
        end
    end

    // index 0: enable toggle field, index 1: service field
    for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
        seqwd_handshake u_hs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (wr_ctrl),
            .code_i (bus_wdata[EN_LSB + FLD_W*g +: FLD_W]),
            .fire_o (cmd_fire[g])
        );
    end

    seqwd_countdown #(
        .RELOAD_W   (RELOAD_W),
        .PRESCALE_W (PRESCALE_W),
        .RST_RELOAD (RST_RELOAD)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (reload_next),
        .dec_i      (dec),
        .thr_i      (thr_q),
        .zero_o     (zero),
        .thr_hit_o  (thr_hit)
    );

    seqwd_ctrl #(
        .BITE_CYCLES (BITE_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .toggle_i  (cmd_fire[0]),
        .service_i (cmd_fire[1]),
        .zero_i    (zero),
        .thr_hit_i (thr_hit),
        .load_o    (load),
        .dec_o     (dec),
        .running_o (running),
        .expired_o (expired),
        .rst_o     (wdt_reset_o),
        .irq_o     (wdt_irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            bus_rdata[RELOAD_W-1:0] = reload_q;
            bus_rdata[RUN_BIT]      = running;
            bus_rdata[FLAG_BIT]     = expired;
        end else if (bus_addr == OFS_THR) begin
            bus_rdata[RELOAD_W-1:0] = thr_q;
        end
    end

    // R2: each control write leaves its low bits as the reload value
    assert_reload_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (reload_q == $past(bus_wdata[RELOAD_W-1:0])));
endmodule

// File: tb/seqwd_timer_tb_top.sv
`timescale 1ns/1ps
module seqwd_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_o;
    logic        wdt_irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    seqwd_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_reset_o (wdt_reset_o),
        .wdt_irq_o   (wdt_irq_o)
    );

    function automatic logic [31:0] cw(input logic [1:0] en, input logic [1:0] sv,
                                       input logic [23:0] rl);
        return {4'b0, sv, en, rl};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic enable_pair(input logic [23:0] rl);
        wr(3'd0, cw(2'd1, 2'd0, rl));
        wr(3'd0, cw(2'd2, 2'd0, rl));
    endtask

    task automatic service_pair(input logic [23:0] rl);
        wr(3'd0, cw(2'd0, 2'd1, rl));
        wr(3'd0, cw(2'd0, 2'd2, rl));
    endtask

    task automatic wait_rst(output int n);
        n = 0;
        while (!wdt_reset_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!wdt_irq_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk(wdt_reset_o == 1'b0, "R1 reset out", 32'(wdt_reset_o), 0);
        chk(wdt_irq_o == 1'b0, "R1 irq", 32'(wdt_irq_o), 0);
        rd(3'd0, v);
        chk(v == 32'h0000_0010, "R1 ctrl word", v, 32'h10);
        rd(3'd4, v);
        chk(v == 32'h0, "R1 threshold", v, 0);
    endtask

    task automatic t_handshake;
        logic [31:0] v;
        wr(3'd0, cw(2'd2, 2'd0, 24'd16));
        rd(3'd0, v);
        chk(v[31] == 1'b0, "R4 lone 2 ignored", v, 32'h10);
        wr(3'd0, cw(2'd1, 2'd0, 24'd16));
        wr(3'd0, cw(2'd0, 2'd0, 24'd16));
        wr(3'd0, cw(2'd2, 2'd0, 24'd16));
        rd(3'd0, v);
        chk(v[31] == 1'b0, "R4 1,0,2 ignored", v, 32'h10);
        wr(3'd0, cw(2'd1, 2'd0, 24'd16));
        wr(3'd0, cw(2'd3, 2'd0, 24'd16));
        wr(3'd0, cw(2'd2, 2'd0, 24'd16));
        rd(3'd0, v);
        chk(v[31] == 1'b0, "R4 1,3,2 ignored", v, 32'h10);
        wr(3'd0, cw(2'd1, 2'd0, 24'd16));
        repeat (5) @(negedge clk);
        wr(3'd0, cw(2'd2, 2'd0, 24'd16));
        rd(3'd0, v);
        chk(v[31] == 1'b1, "R3 1,idle,2 enables", v, 32'h8000_0010);
        enable_pair(24'd16);
        rd(3'd0, v);
        chk(v[31] == 1'b0, "R3 second pair disables", v, 32'h10);
        wr(3'd0, cw(2'd0, 2'd0, 24'h00ABCD));
        rd(3'd0, v);
        chk(v == 32'h0000_ABCD, "R2 reload readback", v, 32'hABCD);
    endtask

    task automatic t_expiry;
        logic [31:0] v;
        int n;
        int hi;
        enable_pair(24'd2);
        service_pair(24'd2);
        wait_rst(n);
        chk(n == 513, "R6 service to reset delay", 32'(n), 513);
        hi = 1;
        while (wdt_reset_o && hi < 100) begin
            @(negedge clk);
            if (wdt_reset_o) hi++;
        end
        chk(hi == 16, "R7 pulse width", 32'(hi), 16);
        rd(3'd0, v);
        chk(v[31:30] == 2'b01, "R7 stopped with flag", v, 32'h4000_0002);
        chk(wdt_irq_o == 1'b0, "R9 no irq with zero threshold", 32'(wdt_irq_o), 0);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        int n;
        int seen;
        enable_pair(24'd2);
        rd(3'd0, v);
        chk(v[30] == 1'b0, "R7 flag clears on enable", v, 32'h8000_0002);
        service_pair(24'd2);
        repeat (100) @(negedge clk);
        enable_pair(24'd2);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wdt_reset_o) seen++;
        end
        chk(seen == 0, "R8 no reset while stopped", 32'(seen), 0);
        enable_pair(24'd2);
        wait_rst(n);
        chk(n == 411, "R8 resumes from held count", 32'(n), 411);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        int n;
        wr(3'd4, 32'd2);
        rd(3'd4, v);
        chk(v == 32'd2, "R9 threshold readback", v, 2);
        enable_pair(24'd9);
        service_pair(24'd4);
        wait_irq(n);
        chk(n == 513, "R5/R9 irq delay uses service reload", 32'(n), 513);
        chk(wdt_reset_o == 1'b0, "R9 no reset at warning", 32'(wdt_reset_o), 0);
        repeat (10) @(negedge clk);
        chk(wdt_irq_o == 1'b1, "R9 irq level holds", 32'(wdt_irq_o), 1);
        service_pair(24'd4);
        chk(wdt_irq_o == 1'b0, "R9 service clears irq", 32'(wdt_irq_o), 0);
        wait_irq(n);
        chk(n == 513, "R5 mid-count service reloads", 32'(n), 513);
        enable_pair(24'd4);
        rd(3'd0, v);
        chk(wdt_irq_o == 1'b0 && v[31] == 1'b0, "R9 disable clears irq",
            {31'b0, wdt_irq_o}, 0);
        wr(3'd4, 32'd0);
    endtask

    task automatic t_bite_lock;
        logic [31:0] v;
        int n;
        int hi;
        enable_pair(24'd1);
        service_pair(24'd1);
        wait_rst(n);
        chk(n == 257, "R6 one-unit period", 32'(n), 257);
        hi = 1;
        wr(3'd0, cw(2'd1, 2'd0, 24'd1));
        if (wdt_reset_o) hi++;
        wr(3'd0, cw(2'd2, 2'd0, 24'd1));
        if (wdt_reset_o) hi++;
        while (wdt_reset_o && hi < 100) begin
            @(negedge clk);
            if (wdt_reset_o) hi++;
        end
        chk(hi == 16, "R10 pulse full length", 32'(hi), 16);
        rd(3'd0, v);
        chk(v[31] == 1'b0, "R10 toggle during pulse ignored", v, 32'h4000_0001);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: run hung");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_expiry();
        t_hold();
        t_irq();
        t_bite_lock();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule